// File: doc/BRIEF.md
# Configuration image checksum verifier and repairer

This block proves or restores the integrity of a configuration image made of 16-bit words kept in an external non-volatile memory. A memory controller sits behind two valid/ready streams: a read request stream that carries a word address, a read response stream that returns the word or an error, and a write request stream that carries an address and a data word. The block reads the image from word 0 upward, one word at a time, and keeps a running 16-bit sum that wraps on overflow.

A one-cycle `start_i` launches an operation, and `mode_i` picks it. In check mode (0) the block reads every word from 0 up to and including the checksum word. It reports the image good when the wrapped sum equals the target constant, 0xBABA by default. In update mode (1) it reads only the words below the checksum word. It then writes the target minus that partial sum into the checksum word, so a later check passes. The checksum word address (default 0x3F) and the target are parameters. At the end of each operation `done_o` pulses. The `img_ok_o` and `err_o` flags keep their values until the next accepted start.

Back-pressure rules: a request valid (`rd_req_valid_o`, `wr_req_valid_o`) stays high, with address and data unchanged, until the matching ready is sampled high at a clock edge. The block raises `rd_rsp_ready_o` only while it waits for the reply to its single outstanding read. A response counts as taken on an edge where both `rd_rsp_valid_i` and `rd_rsp_ready_o` are high. It never has more than one read in flight.

Top module: `csum_guard`

## Requirements
- R1: After reset, `done_o`, `img_ok_o`, `err_o`, `rd_req_valid_o`, `rd_rsp_ready_o` and `wr_req_valid_o` are all 0.
- R2: In check mode (`mode_i`=0) the block requests words 0, 1, ..., CSUM_ADDR in ascending order, one per request, and issues no write.
- R3: At the end of a check without a read error, `img_ok_o` is 1 exactly when the sum modulo 2^16 of words 0..CSUM_ADDR equals TARGET (wraparound included), and `err_o` is 0.
- R4: In update mode (`mode_i`=1) the block requests words 0..CSUM_ADDR-1 in ascending order and then issues exactly one write, to address CSUM_ADDR, with data equal to (TARGET minus the sum of those words) modulo 2^16.
- R5: A response taken with `rd_rsp_err_i`=1 ends the operation at once: no further reads, no write, `done_o` pulses, `err_o`=1 and `img_ok_o`=0.
- R6: `done_o` is high for exactly one cycle per operation. `img_ok_o` and `err_o` hold their values until the next accepted start, which clears both.
- R7: A `start_i` pulse seen while an operation is in progress is ignored: the running operation keeps its mode and address sequence, and only one `done_o` pulse follows.
- R8: While a request valid is high and its ready is low, the valid stays high on the next cycle and the request address stays unchanged.
- R9: An update that completes its write ends with `img_ok_o`=1 and `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 1 | 0 = check, 1 = update |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| img_ok_o | output | 1 | Image good (check) or repair written (update) |
| err_o | output | 1 | Operation aborted on a read error |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request ready |
| rd_req_addr_o | output | AW | Word address to read |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_ready_o | output | 1 | Read response ready |
| rd_rsp_data_i | input | DW | Word returned |
| rd_rsp_err_i | input | 1 | Read failed |
| wr_req_valid_o | output | 1 | Write request valid |
| wr_req_ready_i | input | 1 | Write request ready |
| wr_req_addr_o | output | AW | Word address to write (checksum word) |
| wr_req_data_o | output | DW | Correcting checksum word |

## Verification
The bench builds the block with AW=8, DW=16, TARGET=0xBABA and CSUM_ADDR=7. An eight-word image keeps each operation short, so many random images and modes fit in the run. With eight words, an error can be injected at the first word, in the middle and at the checksum word itself. The default target keeps the wraparound case reachable: seven words of 0xFFFF need a checksum word of 0xBAC1.

// File: rtl/csum_guard_pkg.sv
package csum_guard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_EVAL    = 3'd3,
    ST_WR      = 3'd4
  } cg_state_e;

  typedef enum logic {
    OP_CHECK  = 1'b0,
    OP_UPDATE = 1'b1
  } cg_op_e;

endpackage

// File: rtl/csum_guard_acc.sv
module csum_guard_acc #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] sum_o
);

  logic [DW-1:0] sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (add_i) sum_q <= sum_q + word_i;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/csum_guard_ctrl.sv
module csum_guard_ctrl
  import csum_guard_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned CSUM_ADDR = 'h3F,
  parameter logic [DW-1:0] TARGET  = 16'hBABA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [DW-1:0] sum_i,
  output logic          acc_clr_o,
  output logic          acc_add_o,
  output logic          done_o,
  output logic          img_ok_o,
  output logic          err_o,
  output logic          rd_req_valid_o,
  input  logic          rd_req_ready_i,
  output logic [AW-1:0] rd_req_addr_o,
  input  logic          rd_rsp_valid_i,
  output logic          rd_rsp_ready_o,
  input  logic          rd_rsp_err_i,
  output logic          wr_req_valid_o,
  input  logic          wr_req_ready_i
);

  localparam logic [AW-1:0] LAST_CHECK  = AW'(CSUM_ADDR);
  localparam logic [AW-1:0] LAST_UPDATE = (CSUM_ADDR == 0) ? '0 : AW'(CSUM_ADDR - 1);
  localparam bit            NO_PREFIX   = (CSUM_ADDR == 0);

  cg_state_e     state_q;
  cg_op_e        op_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] last_addr;
  logic          rsp_take;

  assign last_addr = (op_q == OP_UPDATE) ? LAST_UPDATE : LAST_CHECK;
  assign rsp_take  = (state_q == ST_RD_WAIT) && rd_rsp_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_CHECK;
      addr_q   <= '0;
      done_o   <= 1'b0;
      img_ok_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q     <= cg_op_e'(mode_i);
            addr_q   <= '0;
            img_ok_o <= 1'b0;
            err_o    <= 1'b0;
            state_q  <= (mode_i && NO_PREFIX) ? ST_WR : ST_RD_REQ;
          end
        end
        ST_RD_REQ: begin
          if (rd_req_ready_i) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (rd_rsp_valid_i) begin
            if (rd_rsp_err_i) begin
              err_o   <= 1'b1;
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (addr_q == last_addr) begin
              state_q <= (op_q == OP_UPDATE) ? ST_WR : ST_EVAL;
            end else begin
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_EVAL: begin
          img_ok_o <= (sum_i == TARGET);
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        ST_WR: begin
          if (wr_req_ready_i) begin
            img_ok_o <= 1'b1;
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_clr_o      = (state_q == ST_IDLE) && start_i;
  assign acc_add_o      = rsp_take && !rd_rsp_err_i;
  assign rd_req_valid_o = (state_q == ST_RD_REQ);
  assign rd_req_addr_o  = addr_q;
  assign rd_rsp_ready_o = (state_q == ST_RD_WAIT);
  assign wr_req_valid_o = (state_q == ST_WR);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o)); // R8
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid_o && !wr_req_ready_i |=> wr_req_valid_o); // R8
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid_i && rd_rsp_ready_o && rd_rsp_err_i |=> done_o && err_o && !img_ok_o && !wr_req_valid_o && !rd_req_valid_o); // R5
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) && start_i |=> $stable(op_q)); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !img_ok_o); // R5

endmodule

// File: rtl/csum_guard.sv
module csum_guard
  import csum_guard_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned CSUM_ADDR = 'h3F,
  parameter logic [DW-1:0] TARGET  = 16'hBABA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  output logic          done_o,
  output logic          img_ok_o,
  output logic          err_o,
  output logic          rd_req_valid_o,
  input  logic          rd_req_ready_i,
  output logic [AW-1:0] rd_req_addr_o,
  input  logic          rd_rsp_valid_i,
  output logic          rd_rsp_ready_o,
  input  logic [DW-1:0] rd_rsp_data_i,
  input  logic          rd_rsp_err_i,
  output logic          wr_req_valid_o,
  input  logic          wr_req_ready_i,
  output logic [AW-1:0] wr_req_addr_o,
  output logic [DW-1:0] wr_req_data_o
);

  logic          acc_clr;
  logic          acc_add;
  logic [DW-1:0] sum;

  csum_guard_acc #(.DW(DW)) acc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (acc_clr),
    .add_i  (acc_add),
    .word_i (rd_rsp_data_i),
    .sum_o  (sum)
  );

  csum_guard_ctrl #(
    .AW(AW), .DW(DW), .CSUM_ADDR(CSUM_ADDR), .TARGET(TARGET)
  ) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .mode_i         (mode_i),
    .sum_i          (sum),
    .acc_clr_o      (acc_clr),
    .acc_add_o      (acc_add),
    .done_o         (done_o),
    .img_ok_o       (img_ok_o),
    .err_o          (err_o),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_req_addr_o  (rd_req_addr_o),
    .rd_rsp_valid_i (rd_rsp_valid_i),
    .rd_rsp_ready_o (rd_rsp_ready_o),
    .rd_rsp_err_i   (rd_rsp_err_i),
    .wr_req_valid_o (wr_req_valid_o),
    .wr_req_ready_i (wr_req_ready_i)
  );

  assign wr_req_addr_o = AW'(CSUM_ADDR);
  assign wr_req_data_o = TARGET - sum;

endmodule

// File: tb/csum_guard_tb_top.sv
module csum_guard_tb_top;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CA = 7;
  localparam logic [15:0] TGT = 16'hBABA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, mode_i = 1'b0;
  logic done_o, img_ok_o, err_o;
  logic rd_req_valid_o, rd_req_ready_i = 1'b0;
  logic [AW-1:0] rd_req_addr_o;
  logic rd_rsp_valid_i = 1'b0, rd_rsp_ready_o, rd_rsp_err_i = 1'b0;
  logic [DW-1:0] rd_rsp_data_i = '0;
  logic wr_req_valid_o, wr_req_ready_i = 1'b0;
  logic [AW-1:0] wr_req_addr_o;
  logic [DW-1:0] wr_req_data_o;

  always #5 clk = ~clk;

  csum_guard #(.AW(AW), .DW(DW), .CSUM_ADDR(CA), .TARGET(TGT)) dut_i (.*);

  logic [15:0] mem [0:CA];
  int err_at = -1;
  int n_tests = 0, n_fail = 0;
  logic [AW-1:0] rd_log [0:63];
  int rd_n = 0, wr_n = 0, hold_viol = 0;
  logic [AW-1:0] wr_addr_seen;
  logic [15:0] wr_data_seen;

  // memory controller model; all accounting done at negedge
  logic pend = 1'b0;
  logic [AW-1:0] pend_addr;
  logic rq_hs = 0, rs_hs = 0, wq_hs = 0, rq_wait = 0, wq_wait = 0;
  logic [AW-1:0] rq_addr_prev;

  initial begin
    forever begin
      @(negedge clk);
      if (rq_wait && (!rd_req_valid_o || rd_req_addr_o != rq_addr_prev)) hold_viol++;
      if (wq_wait && !wr_req_valid_o) hold_viol++;
      if (rq_hs) begin
        pend = 1'b1; pend_addr = rq_addr_prev;
        if (rd_n < 64) rd_log[rd_n] = rq_addr_prev;
        rd_n++;
      end
      if (rs_hs) begin pend = 1'b0; rd_rsp_valid_i = 1'b0; end
      if (wq_hs) wr_n++;
      rd_req_ready_i = ($urandom % 4) != 0;
      wr_req_ready_i = ($urandom % 3) != 0;
      if (!rd_rsp_valid_i && pend && ($urandom % 3) != 0) begin
        rd_rsp_valid_i = 1'b1;
        rd_rsp_err_i   = (int'(pend_addr) == err_at);
        rd_rsp_data_i  = (pend_addr <= CA) ? mem[pend_addr[2:0]] : 16'h0;
      end
      rq_hs = rd_req_valid_o && rd_req_ready_i;
      rq_wait = rd_req_valid_o && !rd_req_ready_i;
      rq_addr_prev = rd_req_addr_o;
      rs_hs = rd_rsp_valid_i && rd_rsp_ready_o;
      wq_hs = wr_req_valid_o && wr_req_ready_i;
      wq_wait = wr_req_valid_o && !wr_req_ready_i;
      if (wq_hs) begin wr_addr_seen = wr_req_addr_o; wr_data_seen = wr_req_data_o; end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_to(int last);
    logic [15:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + mem[i];
    return s;
  endfunction

  // runs one operation; inject>=0 pulses start (opposite mode) mid-run
  task automatic run_op(bit md, int inject, output bit ok, output bit er);
    int cyc = 0;
    rd_n = 0; wr_n = 0;
    @(negedge clk); start_i = 1'b1; mode_i = md;
    @(negedge clk); start_i = 1'b0; mode_i = ~md;
    chk("R6", "flags cleared by start", {err_o, img_ok_o}, 2'b00);
    while (!done_o && cyc < 5000) begin
      start_i = (cyc == inject);
      @(negedge clk); cyc++;
    end
    start_i = 1'b0;
    if (cyc >= 5000) begin n_fail++; $display("FAIL R6 no done: actual 0 expected 1"); end
    ok = img_ok_o; er = err_o;
    @(negedge clk);
    chk("R6", "done single pulse", done_o, 1'b0);
    repeat (4) @(negedge clk);
    chk("R6", "flags held", {img_ok_o, err_o}, {ok, er});
    chk("R7", "no extra done", done_o, 1'b0);
  endtask

  task automatic check_reads(string req, int n);
    chk(req, "read count", rd_n, n);
    for (int i = 0; i < n && i < 64; i++) chk(req, "read address order", rd_log[i], i);
  endtask

  initial begin
    bit ok, er;
    logic [15:0] exp_w;
    void'($urandom(32'h5EED));
    for (int i = 0; i <= CA; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1", "done", done_o, 0); chk("R1", "ok", img_ok_o, 0); chk("R1", "err", err_o, 0);
    chk("R1", "req valids", {rd_req_valid_o, wr_req_valid_o, rd_rsp_ready_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", {rd_req_valid_o, wr_req_valid_o, done_o}, 0);

    // wraparound image that sums exactly to target
    for (int i = 0; i < CA; i++) mem[i] = 16'hFFFF;
    mem[CA] = 16'hBAC1;
    run_op(0, -1, ok, er);
    chk("R3", "wrap sum valid", {ok, er}, 2'b10);
    check_reads("R2", CA + 1);
    chk("R2", "no write in check", wr_n, 0);

    // random image then repair
    for (int i = 0; i <= CA; i++) mem[i] = 16'($urandom);
    exp_w = TGT - sum_to(CA - 1);
    run_op(1, -1, ok, er);
    check_reads("R4", CA);
    chk("R4", "write count", wr_n, 1);
    chk("R4", "write addr", wr_addr_seen, CA);
    chk("R4", "write data", wr_data_seen, exp_w);
    chk("R9", "update flags", {ok, er}, 2'b10);
    mem[CA] = wr_data_seen;
    run_op(0, -1, ok, er);
    chk("R3", "repaired image valid", {ok, er}, 2'b10);

    mem[3] = mem[3] ^ 16'h0001;
    run_op(0, -1, ok, er);
    chk("R3", "corrupt image invalid", {ok, er}, 2'b00);

    // read errors
    err_at = 2;
    run_op(1, -1, ok, er);
    chk("R5", "update abort flags", {ok, er}, 2'b01);
    chk("R5", "no write after error", wr_n, 0);
    chk("R5", "reads stop at error", rd_n, 3);
    err_at = CA;
    run_op(0, -1, ok, er);
    chk("R5", "check abort at checksum word", {ok, er}, 2'b01);
    chk("R5", "reads in check error", rd_n, CA + 1);
    err_at = 0;
    run_op(0, -1, ok, er);
    chk("R5", "abort at first word", {ok, er, rd_n[3:0]}, {2'b01, 4'd1});
    err_at = -1;

    // start while busy
    run_op(0, 3, ok, er);
    check_reads("R7", CA + 1);
    chk("R7", "no write from ignored update start", wr_n, 0);

    // random operations
    for (int t = 0; t < 24; t++) begin
      bit md = 1'($urandom);
      for (int i = 0; i <= CA; i++) mem[i] = 16'($urandom);
      if (($urandom % 3) == 0) mem[CA] = TGT - sum_to(CA - 1);
      exp_w = TGT - sum_to(CA - 1);
      run_op(md, -1, ok, er);
      if (md) begin
        chk("R4", "random write data", {wr_n[3:0], wr_data_seen}, {4'd1, exp_w});
        chk("R9", "random update flags", {ok, er}, 2'b10);
      end else begin
        chk("R3", "random check result", {ok, er}, {sum_to(CA) == TGT, 1'b0});
        check_reads("R2", CA + 1);
      end
    end

    chk("R8", "request hold violations", hold_viol, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_900_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule